// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Expiry

This block is a free-running watchdog for a small processor subsystem. A counter advances on every clock and, when it reaches the interval chosen by a 2-bit select, it raises a time-out flag. That flag can drive an interrupt request. If reset generation is armed and software does not restart the counter, a one-cycle reset request follows a fixed 512-clock grace period after the flag is set. The system feeds that request back on a separate watchdog-reset input. The watchdog-reset input restarts the counter but leaves reset generation armed. A reset-cause flag records that the watchdog caused the reset.

The control bits for arming reset generation, writing the time-out flag and restarting the counter are guarded. A write to one of them takes effect only after a key pair has been written to an access port: 0xAA and then 0x55. The protected write must then arrive within a short window. Any other write in between cancels the unlock. The interval select and the reset-cause clear are unprotected.

Top module: `wdt_grace`

## Requirements
- R1: After power-on reset (rst_ni low), en_o, iflag_o, cause_o, rwt_o and rst_req_o are 0 and sel_o is 00 (shortest interval).
- R2: With sel_o = 00, iflag_o goes high on the 4096th clock edge after the edge that restarted the counter, and is low one edge earlier.
- R3: With en_o = 1 and no restart, rst_req_o is high for exactly one cycle, 512 edges after the edge that set iflag_o. cause_o goes high on that same edge.
- R4: With en_o = 0, no reset request is issued and cause_o does not change. The counter keeps running and sets iflag_o again one interval after the previous time-out.
- R5: An accepted restart write clears the counter and cancels a pending grace period. rwt_o reads 1 for one cycle after the write and then 0 without any further write.
- R6: A pulse on wd_rst_i clears the counter, iflag_o and sel_o (back to 00). It keeps en_o and cause_o unchanged.
- R7: sel_o codes 00, 01, 10 and 11 select intervals of 2^12, 2^15, 2^18 and 2^20 clocks. The select is written with sel_we_i and needs no unlock.
- R8: Writes through en_we_i, iflag_we_i and restart_we_i are ignored unless the access port has received 0xAA and then 0x55. After the 0x55 write, the protected write is accepted only in the next 4 cycles. Any other write between the keys, or between the 0x55 write and the protected write, cancels the unlock. Each accepted protected write uses up the unlock.
- R9: Software clears iflag_o with an unlocked write of 0 through iflag_we_i. It clears cause_o with cause_clr_i, which needs no unlock. Either change is visible one edge later.
- R10: irq_o is high exactly when iflag_o and irq_en_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on / power-fail reset, active low, asynchronous |
| wd_rst_i | input | 1 | Watchdog-initiated system reset fed back, synchronous, active high |
| acc_we_i | input | 1 | Write strobe of the access (unlock) port |
| acc_wdata_i | input | 8 | Data written to the access port |
| en_we_i | input | 1 | Protected write strobe for the reset-enable bit |
| en_wdata_i | input | 1 | New reset-enable value |
| iflag_we_i | input | 1 | Protected write strobe for the time-out flag |
| iflag_wdata_i | input | 1 | New time-out flag value |
| restart_we_i | input | 1 | Protected write of 1 to the restart bit |
| sel_we_i | input | 1 | Write strobe for the interval select |
| sel_wdata_i | input | 2 | New interval select code |
| cause_clr_i | input | 1 | Clears the reset-cause flag |
| irq_en_i | input | 1 | Watchdog interrupt enable |
| irq_o | output | 1 | Interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |
| en_o | output | 1 | Reset-enable bit |
| iflag_o | output | 1 | Time-out flag |
| cause_o | output | 1 | Reset-cause flag |
| rwt_o | output | 1 | Restart bit, clears itself |
| sel_o | output | 2 | Current interval select |

## Verification
Every registered result shows up on the first edge that captures its stimulus. These results are the flags, the enable, the select and the restart bit. The time-out is due 2^N edges after the restart edge. The reset request is due 512 edges after the time-out edge and lasts one cycle. The interrupt output is combinational and follows the flag in the same cycle. The bench computes each target edge number before it drives the stimulus and queues the expected value under that number. The monitor compares on the falling edge of that cycle, and it also checks the edge just before each time-out, so an off-by-one in either direction is caught.

// File: rtl/wdt_grace_pkg.sv
package wdt_grace_pkg;

    // Unlock sequencer states
    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_KEY1 = 2'd1,
        LK_OPEN = 2'd2
    } lk_state_e;

    // Architectural control and status state of the watchdog
    typedef struct packed {
        logic       en;       // reset generation armed
        logic       iflag;    // time-out flag
        logic       cause;    // watchdog caused the last reset
        logic       rwt;      // restart bit, self-clearing
        logic       rst_req;  // one-cycle reset request
        logic [1:0] sel;      // interval select
    } wdt_ctl_t;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_grace_pkg::*;
#(
    parameter logic [7:0]  KEY1 = 8'hAA,
    parameter logic [7:0]  KEY2 = 8'h55,
    parameter int unsigned WIN  = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       acc_we_i,
    input  logic [7:0] acc_wdata_i,
    input  logic       prot_we_i,
    input  logic       other_we_i,
    output logic       open_o
);

    localparam int unsigned WW = $clog2(WIN + 1);

    typedef struct packed {
        lk_state_e     st;
        logic [WW-1:0] win;
    } lk_t;

    lk_t lk_q, lk_d;

    always_comb begin
        lk_d = lk_q;
        if (acc_we_i) begin
            if (acc_wdata_i == KEY1) begin
                lk_d.st  = LK_KEY1;
                lk_d.win = '0;
            end else if (lk_q.st == LK_KEY1 && acc_wdata_i == KEY2) begin
                lk_d.st  = LK_OPEN;
                lk_d.win = WW'(WIN);
            end else begin
                lk_d.st  = LK_IDLE;
                lk_d.win = '0;
            end
        end else if (prot_we_i || other_we_i) begin
            // a protected write consumes the unlock, any other write aborts it
            lk_d.st  = LK_IDLE;
            lk_d.win = '0;
        end else if (lk_q.st == LK_OPEN) begin
            lk_d.win = lk_q.win - WW'(1);
            if (lk_q.win <= WW'(1)) begin
                lk_d.st = LK_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lk_q <= '{st: LK_IDLE, win: '0};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign open_o = (lk_q.st == LK_OPEN);

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int unsigned EXP0  = 12,
    parameter int unsigned EXP1  = 15,
    parameter int unsigned EXP2  = 18,
    parameter int unsigned EXP3  = 20,
    parameter int unsigned CNT_W = 20
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic [1:0] sel_i,
    output logic       tmo_o
);

    localparam int unsigned NSEL = 4;
    localparam int unsigned EXPS [NSEL] = '{EXP0, EXP1, EXP2, EXP3};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t             cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_tab [NSEL];
    logic             tmo_raw;

    // terminal count for each select code
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tab[g] = CNT_W'((64'd1 << EXPS[g]) - 64'd1);
    end

    assign tmo_raw = (cnt_q.cnt >= lim_tab[sel_i]);

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d.cnt = '0;
        end else if (tmo_raw) begin
            cnt_d.cnt = '0;
        end else begin
            cnt_d.cnt = cnt_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // a restart on the terminal cycle suppresses the time-out
    assign tmo_o = tmo_raw && !clr_i;

endmodule

// File: rtl/wdt_grace_tmr.sv
module wdt_grace_tmr #(
    parameter int unsigned GRACE = 512
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic cancel_i,
    output logic expire_o
);

    localparam int unsigned GW = $clog2(GRACE);

    typedef struct packed {
        logic          active;
        logic [GW-1:0] cnt;
    } gr_t;

    gr_t gr_q, gr_d;

    assign expire_o = gr_q.active && (gr_q.cnt == GW'(GRACE - 1));

    always_comb begin
        gr_d = gr_q;
        if (cancel_i) begin
            gr_d.active = 1'b0;
            gr_d.cnt    = '0;
        end else if (start_i) begin
            gr_d.active = 1'b1;
            gr_d.cnt    = '0;
        end else if (expire_o) begin
            gr_d.active = 1'b0;
            gr_d.cnt    = '0;
        end else if (gr_q.active) begin
            gr_d.cnt = gr_q.cnt + GW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            gr_q <= '0;
        end else begin
            gr_q <= gr_d;
        end
    end

endmodule

// File: rtl/wdt_grace.sv
module wdt_grace
    import wdt_grace_pkg::*;
#(
    parameter int unsigned EXP0  = 12,
    parameter int unsigned EXP1  = 15,
    parameter int unsigned EXP2  = 18,
    parameter int unsigned EXP3  = 20,
    parameter int unsigned GRACE = 512,
    parameter int unsigned WIN   = 4,
    parameter logic [7:0]  KEY1  = 8'hAA,
    parameter logic [7:0]  KEY2  = 8'h55
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wd_rst_i,
    input  logic       acc_we_i,
    input  logic [7:0] acc_wdata_i,
    input  logic       en_we_i,
    input  logic       en_wdata_i,
    input  logic       iflag_we_i,
    input  logic       iflag_wdata_i,
    input  logic       restart_we_i,
    input  logic       sel_we_i,
    input  logic [1:0] sel_wdata_i,
    input  logic       cause_clr_i,
    input  logic       irq_en_i,
    output logic       irq_o,
    output logic       rst_req_o,
    output logic       en_o,
    output logic       iflag_o,
    output logic       cause_o,
    output logic       rwt_o,
    output logic [1:0] sel_o
);

    localparam int unsigned MAX01 = (EXP0 > EXP1) ? EXP0 : EXP1;
    localparam int unsigned MAX23 = (EXP2 > EXP3) ? EXP2 : EXP3;
    localparam int unsigned CNT_W = (MAX01 > MAX23) ? MAX01 : MAX23;

    wdt_ctl_t ctl_q, ctl_d;

    logic lk_open;
    logic prot_we;
    logic other_we;
    logic en_acc;
    logic iflag_acc;
    logic rst_acc;
    logic cnt_clr;
    logic tmo;
    logic expire;

    assign prot_we   = en_we_i | iflag_we_i | restart_we_i;
    assign other_we  = sel_we_i | cause_clr_i;
    assign en_acc    = en_we_i      & lk_open;
    assign iflag_acc = iflag_we_i   & lk_open;
    assign rst_acc   = restart_we_i & lk_open;
    assign cnt_clr   = rst_acc | wd_rst_i;

    wdt_unlock #(
        .KEY1 (KEY1),
        .KEY2 (KEY2),
        .WIN  (WIN)
    ) i_unlock (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .acc_we_i    (acc_we_i),
        .acc_wdata_i (acc_wdata_i),
        .prot_we_i   (prot_we),
        .other_we_i  (other_we),
        .open_o      (lk_open)
    );

    wdt_count #(
        .EXP0  (EXP0),
        .EXP1  (EXP1),
        .EXP2  (EXP2),
        .EXP3  (EXP3),
        .CNT_W (CNT_W)
    ) i_count (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .sel_i  (ctl_q.sel),
        .tmo_o  (tmo)
    );

    wdt_grace_tmr #(
        .GRACE (GRACE)
    ) i_grace (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (tmo),
        .cancel_i (cnt_clr),
        .expire_o (expire)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.rwt     = 1'b0;
        ctl_d.rst_req = 1'b0;
        if (sel_we_i) begin
            ctl_d.sel = sel_wdata_i;
        end
        if (en_acc) begin
            ctl_d.en = en_wdata_i;
        end
        if (iflag_acc) begin
            ctl_d.iflag = iflag_wdata_i;
        end
        if (rst_acc) begin
            ctl_d.rwt = 1'b1;
        end
        if (tmo) begin
            ctl_d.iflag = 1'b1;
        end
        if (cause_clr_i) begin
            ctl_d.cause = 1'b0;
        end
        if (expire && ctl_q.en && !wd_rst_i) begin
            ctl_d.rst_req = 1'b1;
            ctl_d.cause   = 1'b1;
        end
        if (wd_rst_i) begin
            // watchdog reset restarts but keeps the arming and the cause
            ctl_d.iflag   = 1'b0;
            ctl_d.rwt     = 1'b0;
            ctl_d.rst_req = 1'b0;
            ctl_d.sel     = 2'b00;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_o     = ctl_q.iflag & irq_en_i;
    assign rst_req_o = ctl_q.rst_req;
    assign en_o      = ctl_q.en;
    assign iflag_o   = ctl_q.iflag;
    assign cause_o   = ctl_q.cause;
    assign rwt_o     = ctl_q.rwt;
    assign sel_o     = ctl_q.sel;

endmodule

// File: rtl/wdt_grace_chk.sv
module wdt_grace_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic wd_rst_i,
    input logic en_we_i,
    input logic unlocked_i,
    input logic rst_req_o,
    input logic en_o,
    input logic iflag_o,
    input logic cause_o,
    input logic rwt_o
);

    // R3: reset request lasts a single cycle
    p_rst_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    // R3: cause flag only rises together with a reset request
    p_cause_with_rst_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cause_o) |-> rst_req_o);

    // R4: no reset request unless reset generation was armed
    p_rst_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> $past(en_o));

    // R5: restart bit clears itself
    p_rwt_selfclr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rwt_o |=> !rwt_o);

    // R6: watchdog reset clears the flag and keeps the arming
    p_wdrst_keep_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wd_rst_i && !en_we_i) |=> (!iflag_o && (en_o == $past(en_o))));

    // R8: a locked enable write leaves the enable unchanged
    p_locked_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_we_i && !unlocked_i) |=> $stable(en_o));

endmodule

bind wdt_grace wdt_grace_chk i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wd_rst_i   (wd_rst_i),
    .en_we_i    (en_we_i),
    .unlocked_i (lk_open),
    .rst_req_o  (rst_req_o),
    .en_o       (en_o),
    .iflag_o    (iflag_o),
    .cause_o    (cause_o),
    .rwt_o      (rwt_o)
);

// File: tb/test_wdt_grace.sv
module test_wdt_grace;

    localparam int S_EN = 0, S_IFLAG = 1, S_CAUSE = 2, S_RWT = 3, S_RST = 4, S_IRQ = 5, S_SEL = 6;
    localparam int W_EN = 0, W_IFLAG = 1, W_RESTART = 2, W_SEL = 3, W_CCLR = 4, W_WDRST = 5;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wd_rst = 1'b0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic       en_we = 1'b0, en_wdata = 1'b0;
    logic       iflag_we = 1'b0, iflag_wdata = 1'b0;
    logic       restart_we = 1'b0;
    logic       sel_we = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       cause_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq, rst_req, en, iflag, cause, rwt;
    logic [1:0] sel;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int    cyc;
        int    sig;
        int    exp;
        string tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wdt_grace i_wdt_grace (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .wd_rst_i      (wd_rst),
        .acc_we_i      (acc_we),
        .acc_wdata_i   (acc_wdata),
        .en_we_i       (en_we),
        .en_wdata_i    (en_wdata),
        .iflag_we_i    (iflag_we),
        .iflag_wdata_i (iflag_wdata),
        .restart_we_i  (restart_we),
        .sel_we_i      (sel_we),
        .sel_wdata_i   (sel_wdata),
        .cause_clr_i   (cause_clr),
        .irq_en_i      (irq_en),
        .irq_o         (irq),
        .rst_req_o     (rst_req),
        .en_o          (en),
        .iflag_o       (iflag),
        .cause_o       (cause),
        .rwt_o         (rwt),
        .sel_o         (sel)
    );

    function automatic int observe(int s);
        case (s)
            S_EN:    return int'(en);
            S_IFLAG: return int'(iflag);
            S_CAUSE: return int'(cause);
            S_RWT:   return int'(rwt);
            S_RST:   return int'(rst_req);
            S_IRQ:   return int'(irq);
            default: return int'(sel);
        endcase
    endfunction

    task automatic expect_at(int c, int s, int e, string tag);
        sb.push_back('{cyc: c, sig: s, exp: e, tag: tag});
    endtask

    // monitor: compare queued expectations on the falling edge of their cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
                n_chk++;
                if (observe(sb[i].sig) != sb[i].exp) begin
                    n_fail++;
                    $display("FAIL %s cycle %0d signal %0d: actual %0d expected %0d",
                             sb[i].tag, cyc, sb[i].sig, observe(sb[i].sig), sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic acc_write(logic [7:0] v);
        acc_we    = 1'b1;
        acc_wdata = v;
        @(negedge clk);
        acc_we    = 1'b0;
    endtask

    task automatic unlock();
        acc_write(8'hAA);
        acc_write(8'h55);
    endtask

    task automatic strobe(int which, int v);
        case (which)
            W_EN:      begin en_we = 1'b1; en_wdata = v[0]; end
            W_IFLAG:   begin iflag_we = 1'b1; iflag_wdata = v[0]; end
            W_RESTART: restart_we = 1'b1;
            W_SEL:     begin sel_we = 1'b1; sel_wdata = v[1:0]; end
            W_CCLR:    cause_clr = 1'b1;
            default:   wd_rst = 1'b1;
        endcase
        @(negedge clk);
        en_we = 1'b0; iflag_we = 1'b0; restart_we = 1'b0;
        sel_we = 1'b0; cause_clr = 1'b0; wd_rst = 1'b0;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            foreach (sb[i]) begin
                n_chk++;
                n_fail++;
                $display("FAIL %s never sampled at cycle %0d: actual none expected %0d",
                         sb[i].tag, sb[i].cyc, sb[i].exp);
            end
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= LIMIT);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual cycle %0d expected end before %0d", cyc, LIMIT);
        finish_run();
    end

    initial begin
        int e, t, w, r, t2, t3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        e = cyc + 1;
        expect_at(e, S_EN, 0, "R1");
        expect_at(e, S_IFLAG, 0, "R1");
        expect_at(e, S_CAUSE, 0, "R1");
        expect_at(e, S_RWT, 0, "R1");
        expect_at(e, S_RST, 0, "R1");
        expect_at(e, S_SEL, 0, "R1");
        @(negedge clk);

        // R8: locked write ignored
        e = cyc + 1;
        expect_at(e, S_EN, 0, "R8 locked");
        strobe(W_EN, 1);
        // R8: window expired after 4 idle cycles
        unlock();
        repeat (4) @(negedge clk);
        e = cyc + 1;
        expect_at(e, S_EN, 0, "R8 window expired");
        strobe(W_EN, 1);
        // R8: intervening write aborts the key sequence
        acc_write(8'hAA);
        strobe(W_SEL, 0);
        acc_write(8'h55);
        e = cyc + 1;
        expect_at(e, S_EN, 0, "R8 aborted");
        strobe(W_EN, 1);
        // R8: last cycle of the window still accepted
        unlock();
        repeat (3) @(negedge clk);
        e = cyc + 1;
        expect_at(e, S_EN, 1, "R8 last window cycle");
        strobe(W_EN, 1);

        // R2, R3, R5, R10: restart, time-out, grace and reset pulse
        unlock();
        t = cyc + 1;
        expect_at(t, S_RWT, 1, "R5 rwt set");
        expect_at(t + 1, S_RWT, 0, "R5 rwt self-clear");
        expect_at(t + 4095, S_IFLAG, 0, "R2 before time-out");
        expect_at(t + 4096, S_IFLAG, 1, "R2 time-out");
        expect_at(t + 4096, S_IRQ, 0, "R10 irq masked");
        expect_at(t + 4607, S_RST, 0, "R3 before grace end");
        expect_at(t + 4607, S_CAUSE, 0, "R3 cause before");
        expect_at(t + 4608, S_RST, 1, "R3 reset pulse");
        expect_at(t + 4608, S_CAUSE, 1, "R3 cause set");
        expect_at(t + 4609, S_RST, 0, "R3 single cycle");
        strobe(W_RESTART, 1);
        wait_to(t + 4097);
        irq_en = 1'b1;
        expect_at(t + 4098, S_IRQ, 1, "R10 irq enabled");
        wait_to(t + 4610);

        // R7, R6: select write, then watchdog reset input
        e = cyc + 1;
        expect_at(e, S_SEL, 1, "R7 select write");
        strobe(W_SEL, 1);
        w = cyc + 1;
        expect_at(w, S_IFLAG, 0, "R6 flag cleared");
        expect_at(w, S_IRQ, 0, "R10 irq follows flag");
        expect_at(w, S_EN, 1, "R6 enable kept");
        expect_at(w, S_CAUSE, 1, "R6 cause kept");
        expect_at(w, S_SEL, 0, "R6 select cleared");
        expect_at(w + 4095, S_IFLAG, 0, "R6 counter restarted");
        expect_at(w + 4096, S_IFLAG, 1, "R6 counter restarted");
        strobe(W_WDRST, 1);
        wait_to(w + 4097);

        // R9: software clears of cause and flag
        e = cyc + 1;
        expect_at(e, S_CAUSE, 0, "R9 cause clear");
        strobe(W_CCLR, 1);
        unlock();
        e = cyc + 1;
        expect_at(e, S_IFLAG, 0, "R9 flag clear");
        expect_at(e, S_IRQ, 0, "R10 irq low");
        strobe(W_IFLAG, 0);
        // R5: restart during grace cancels the reset
        unlock();
        r = cyc + 1;
        expect_at(w + 4608, S_RST, 0, "R5 grace cancelled");
        expect_at(w + 4609, S_RST, 0, "R5 grace cancelled");
        expect_at(w + 4620, S_CAUSE, 0, "R5 no cause");
        expect_at(r + 4095, S_IFLAG, 0, "R5 counter cleared");
        strobe(W_RESTART, 1);
        wait_to(w + 4621);

        // R4: disarmed reset, counter keeps running
        unlock();
        e = cyc + 1;
        expect_at(e, S_EN, 0, "R4 disarm");
        strobe(W_EN, 0);
        unlock();
        t2 = cyc + 1;
        expect_at(t2 + 4096, S_IFLAG, 1, "R4 flag still works");
        expect_at(t2 + 4608, S_RST, 0, "R4 no reset");
        expect_at(t2 + 4609, S_RST, 0, "R4 no reset");
        expect_at(t2 + 4700, S_CAUSE, 0, "R4 cause unchanged");
        strobe(W_RESTART, 1);
        wait_to(t2 + 4700);
        unlock();
        e = cyc + 1;
        expect_at(e, S_IFLAG, 0, "R9 flag clear");
        expect_at(t2 + 8191, S_IFLAG, 0, "R4 running");
        expect_at(t2 + 8192, S_IFLAG, 1, "R4 second time-out");
        strobe(W_IFLAG, 0);
        wait_to(t2 + 8193);

        // R7: code 01 gives 2^15
        e = cyc + 1;
        expect_at(e, S_SEL, 1, "R7 select 01");
        strobe(W_SEL, 1);
        unlock();
        e = cyc + 1;
        expect_at(e, S_IFLAG, 0, "R9 flag clear");
        strobe(W_IFLAG, 0);
        unlock();
        t3 = cyc + 1;
        expect_at(t3 + 32767, S_IFLAG, 0, "R7 before long time-out");
        expect_at(t3 + 32768, S_IFLAG, 1, "R7 long time-out");
        strobe(W_RESTART, 1);
        wait_to(t3 + 32770);

        finish_run();
    end

endmodule